// File: doc/BRIEF.md
# Offset-Updating Load/Store Unit with Dual-Write Register File

This block holds four 16-bit general registers and executes one memory access per accepted command, optionally rewriting the base register in the same cycle. In post-offset mode the memory address is the current base register, and base plus offset is written back to it. In pre-offset mode the sum is computed first, used as the address and written back. A load commits its memory data and the updated base on the same clock edge. This turns an add-plus-access pair into one instruction.

The command side carries a store/load select, a mode bit, a base-update enable, a data register index, a base register index and a 16-bit offset. The memory side is a word RAM with a valid/ready handshake, and its read data is valid in the cycle where ready is high. A command completes in the cycle where both `cmd_valid` and `mem_ready` are high. The register file has two write ports. The load-data port has priority over the base-update port.

Top module: `offset_lsu`

## Requirements
- R1: With `cmd_pre`=0 (post-offset), `mem_addr` equals the base register selected by `cmd_base`.
- R2: With `cmd_pre`=1 (pre-offset), `mem_addr` equals the base register plus `cmd_off`.
- R3: When `cmd_wb`=1 and a command completes, the base register takes base plus `cmd_off` in both modes. Unless R5 applies, the new value is readable from the next cycle.
- R4: When a load (`cmd_store`=0) completes, register `cmd_dst` takes `mem_rdata` on the same edge as any base update.
- R5: If a load with `cmd_wb`=1 has `cmd_dst` equal to `cmd_base`, the register ends up holding the loaded data.
- R6: For a store (`cmd_store`=1), `mem_we` is 1 and `mem_wdata` is register `cmd_dst` as it was before the access. A store writes no register except the base, when `cmd_wb`=1.
- R7: With `cmd_wb`=0 the base register is left unchanged.
- R8: No register changes in a cycle without a completed command. While `mem_ready` is low, the address and store data stay steady.
- R9: Reset (`rst` high, synchronous) clears all four registers to zero.
- R10: Offset addition wraps modulo 2^16, so a base of 0xFFF8 plus 0x0010 gives 0x0008.
- R11: `mem_valid` follows `cmd_valid`, and `cmd_ready` follows `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command completes this cycle when valid |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_pre | input | 1 | 1 = pre-offset, 0 = post-offset |
| cmd_wb | input | 1 | 1 = write base plus offset back to the base |
| cmd_dst | input | 2 | Load destination or store source register |
| cmd_base | input | 2 | Base register index |
| cmd_off | input | 16 | Offset added to the base |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts or returns data this cycle |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Load data, valid while `mem_ready` is high |

## Verification
The assertions check several things on every cycle against the live register state: the address for each mode, the store data, the handshake mirroring, and the register contents after each completed command. That covers the base-update sum, the load result, the collision winner, and the absence of changes when nothing completes or when the base update is off. Some behaviours need the bench's command sequences to show them. These are reset contents, wrap-around of a real near-top base, held outputs across memory wait states, and a store whose source is also its base. In those sequences a later command reads back the registers an earlier one wrote.

// File: rtl/offset_lsu_pkg.sv
package offset_lsu_pkg;
    localparam int unsigned LSU_DW   = 16;
    localparam int unsigned LSU_NREG = 4;
    localparam int unsigned LSU_RW   = $clog2(LSU_NREG);

    typedef logic [LSU_DW-1:0] word_t;
    typedef logic [LSU_RW-1:0] ridx_t;

    typedef enum logic {
        OFS_POST = 1'b0,
        OFS_PRE  = 1'b1
    } ofs_mode_e;

    typedef struct packed {
        logic  en;
        ridx_t idx;
        word_t data;
    } wr_port_t;

    function automatic word_t wrap_add(input word_t a, input word_t b);
        return a + b;
    endfunction
endpackage

// File: rtl/lsu_regfile.sv
module lsu_regfile
    import offset_lsu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ridx_t    rd_a_idx,
    output word_t    rd_a_data,
    input  ridx_t    rd_b_idx,
    output word_t    rd_b_data,
    input  wr_port_t wr_pri,
    input  wr_port_t wr_sec,
    output logic [LSU_NREG-1:0][LSU_DW-1:0] state_o
);
    word_t q [LSU_NREG];

    for (genvar i = 0; i < LSU_NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= '0;
            end else if (wr_pri.en && wr_pri.idx == ridx_t'(i)) begin
                q[i] <= wr_pri.data;
            end else if (wr_sec.en && wr_sec.idx == ridx_t'(i)) begin
                q[i] <= wr_sec.data;
            end
        end
        assign state_o[i] = q[i];
    end

    assign rd_a_data = q[rd_a_idx];
    assign rd_b_data = q[rd_b_idx];
endmodule

// File: rtl/lsu_agu.sv
module lsu_agu
    import offset_lsu_pkg::*;
(
    input  word_t     base_val,
    input  word_t     offset,
    input  ofs_mode_e mode,
    output word_t     addr,
    output word_t     sum
);
    always_comb begin
        sum  = wrap_add(base_val, offset);
        addr = (mode == OFS_PRE) ? sum : base_val;
    end
endmodule

// File: rtl/lsu_wb_ctrl.sv
module lsu_wb_ctrl
    import offset_lsu_pkg::*;
(
    input  logic     fire,
    input  logic     is_store,
    input  logic     base_upd,
    input  ridx_t    dst_idx,
    input  ridx_t    base_idx,
    input  word_t    new_base,
    input  word_t    load_data,
    output wr_port_t wr_load,
    output wr_port_t wr_base
);
    always_comb begin
        wr_load.en   = fire && !is_store;
        wr_load.idx  = dst_idx;
        wr_load.data = load_data;
        wr_base.en   = fire && base_upd;
        wr_base.idx  = base_idx;
        wr_base.data = new_base;
    end
endmodule

// File: rtl/offset_lsu.sv
module offset_lsu
    import offset_lsu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic        cmd_store,
    input  logic        cmd_pre,
    input  logic        cmd_wb,
    input  logic [1:0]  cmd_dst,
    input  logic [1:0]  cmd_base,
    input  logic [15:0] cmd_off,
    output logic        mem_valid,
    input  logic        mem_ready,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata
);
    word_t    base_val;
    word_t    src_val;
    word_t    sum_val;
    word_t    addr_val;
    wr_port_t wr_load;
    wr_port_t wr_base;
    logic     fire;
    logic [LSU_NREG-1:0][LSU_DW-1:0] rf_state;

    assign fire = cmd_valid && mem_ready;

    lsu_regfile u_rf (
        .clk       (clk),
        .rst       (rst),
        .rd_a_idx  (cmd_base),
        .rd_a_data (base_val),
        .rd_b_idx  (cmd_dst),
        .rd_b_data (src_val),
        .wr_pri    (wr_load),
        .wr_sec    (wr_base),
        .state_o   (rf_state)
    );

    lsu_agu u_agu (
        .base_val (base_val),
        .offset   (cmd_off),
        .mode     (ofs_mode_e'(cmd_pre)),
        .addr     (addr_val),
        .sum      (sum_val)
    );

    lsu_wb_ctrl u_wb (
        .fire      (fire),
        .is_store  (cmd_store),
        .base_upd  (cmd_wb),
        .dst_idx   (cmd_dst),
        .base_idx  (cmd_base),
        .new_base  (sum_val),
        .load_data (mem_rdata),
        .wr_load   (wr_load),
        .wr_base   (wr_base)
    );

    assign mem_valid = cmd_valid;
    assign cmd_ready = mem_ready;
    assign mem_we    = cmd_valid && cmd_store;
    assign mem_addr  = addr_val;
    assign mem_wdata = src_val;
endmodule

// File: rtl/offset_lsu_chk.sv
module offset_lsu_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        cmd_store,
    input logic        cmd_pre,
    input logic        cmd_wb,
    input logic [1:0]  cmd_dst,
    input logic [1:0]  cmd_base,
    input logic [15:0] cmd_off,
    input logic        mem_valid,
    input logic        mem_ready,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [15:0] mem_wdata,
    input logic [15:0] mem_rdata,
    input logic [3:0][15:0] rf_state
);
    logic        fire_c;
    logic [15:0] exp_sum;
    logic        collide;

    assign fire_c  = cmd_valid && mem_ready;
    assign exp_sum = rf_state[cmd_base] + cmd_off;
    assign collide = !cmd_store && cmd_wb && (cmd_dst == cmd_base);

    a_r1_post_addr: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !cmd_pre) |-> mem_addr == rf_state[cmd_base]);

    a_r2_pre_addr: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && cmd_pre) |-> mem_addr == exp_sum);

    a_r3_base_update: assert property (@(posedge clk) disable iff (rst)
        (fire_c && cmd_wb && !collide) |=> rf_state[$past(cmd_base)] == $past(exp_sum));

    a_r4_load_data: assert property (@(posedge clk) disable iff (rst)
        (fire_c && !cmd_store) |=> rf_state[$past(cmd_dst)] == $past(mem_rdata));

    a_r5_load_wins: assert property (@(posedge clk) disable iff (rst)
        (fire_c && collide) |=> rf_state[$past(cmd_base)] == $past(mem_rdata));

    a_r6_store_data: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && cmd_store) |-> (mem_we && mem_wdata == rf_state[cmd_dst]));

    a_r7_no_update: assert property (@(posedge clk) disable iff (rst)
        (fire_c && cmd_store && !cmd_wb) |=> rf_state == $past(rf_state));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !fire_c |=> $stable(rf_state));

    a_r11_handshake: assert property (@(posedge clk) disable iff (rst)
        (mem_valid == cmd_valid) && (cmd_ready == mem_ready));
endmodule

bind offset_lsu offset_lsu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_store (cmd_store),
    .cmd_pre   (cmd_pre),
    .cmd_wb    (cmd_wb),
    .cmd_dst   (cmd_dst),
    .cmd_base  (cmd_base),
    .cmd_off   (cmd_off),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .rf_state  (rf_state)
);

// File: tb/tb_offset_lsu.sv
`timescale 1ns/1ps
module tb_offset_lsu;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid, cmd_ready, cmd_store, cmd_pre, cmd_wb;
    logic [1:0]  cmd_dst, cmd_base;
    logic [15:0] cmd_off;
    logic        mem_valid, mem_ready, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    logic [15:0] mem [256];
    logic [15:0] m_reg [4];
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    offset_lsu dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_store(cmd_store), .cmd_pre(cmd_pre), .cmd_wb(cmd_wb),
        .cmd_dst(cmd_dst), .cmd_base(cmd_base), .cmd_off(cmd_off),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    always_ff @(posedge clk) begin
        if (mem_valid && mem_ready && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end

    typedef struct packed {
        bit        st;
        bit        pre;
        bit        wb;
        bit [1:0]  dst;
        bit [1:0]  base;
        bit [15:0] off;
        bit [3:0]  wt;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 1'b0, 2'd1, 2'd0, 16'h0020, 4'd0},
        '{1'b0, 1'b1, 1'b0, 2'd2, 2'd0, 16'h00C8, 4'd1},
        '{1'b0, 1'b1, 1'b0, 2'd3, 2'd0, 16'h0004, 4'd0},
        '{1'b0, 1'b0, 1'b1, 2'd0, 2'd1, 16'h0002, 4'd0},
        '{1'b0, 1'b1, 1'b1, 2'd3, 2'd2, 16'h0010, 4'd2},
        '{1'b1, 1'b0, 1'b1, 2'd3, 2'd1, 16'hFFFE, 4'd0},
        '{1'b1, 1'b1, 1'b1, 2'd0, 2'd2, 16'h0030, 4'd1},
        '{1'b0, 1'b0, 1'b1, 2'd1, 2'd1, 16'h0005, 4'd0},
        '{1'b0, 1'b1, 1'b1, 2'd2, 2'd2, 16'h0001, 4'd0},
        '{1'b1, 1'b1, 1'b1, 2'd3, 2'd3, 16'h0002, 4'd0},
        '{1'b0, 1'b0, 1'b0, 2'd0, 2'd2, 16'h0000, 4'd3},
        '{1'b1, 1'b1, 1'b0, 2'd1, 2'd0, 16'h0007, 4'd0}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One command; checks address/data every cycle, updates the reference model after the commit edge.
    task automatic op(input bit st, input bit pre, input bit wb, input bit [1:0] dst,
                      input bit [1:0] base, input bit [15:0] off, input int wt, input string tag);
        logic [15:0] sum, addr, ld, src;
        sum  = m_reg[base] + off;
        addr = pre ? sum : m_reg[base];
        src  = m_reg[dst];
        cmd_valid = 1'b1; cmd_store = st; cmd_pre = pre; cmd_wb = wb;
        cmd_dst = dst; cmd_base = base; cmd_off = off;
        mem_ready = 1'b0;
        for (int w = 0; w < wt; w++) begin
            #1;
            chk("R11 ready low in wait", {15'd0, cmd_ready}, 16'd0);
            chk("R8 address held in wait", mem_addr, addr);
            @(negedge clk);
        end
        mem_ready = 1'b1;
        #1;
        chk(tag, mem_addr, addr);
        chk("R11 valid mirror", {15'd0, mem_valid}, 16'd1);
        if (st) begin
            chk("R6 store enable", {15'd0, mem_we}, 16'd1);
            chk("R6 store data", mem_wdata, src);
        end
        ld = mem[addr[7:0]];
        @(posedge clk);
        if (wb) m_reg[base] = sum;
        if (!st) m_reg[dst] = ld;
        @(negedge clk);
        cmd_valid = 1'b0;
        mem_ready = 1'b0;
    endtask

    // Read a register out through a store at its own value (pre-offset, zero offset, no update).
    task automatic dump(input bit [1:0] r, input string tag);
        op(1'b1, 1'b1, 1'b0, r, r, 16'h0000, 0, tag);
    endtask

    task automatic dump_all(input string tag);
        for (int r = 0; r < 4; r++) dump(2'(r), tag);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] base_before;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 5 + 3);
        mem[200] = 16'hFFF8;
        for (int i = 0; i < 4; i++) m_reg[i] = 16'h1234;
        rst = 1'b1; cmd_valid = 1'b0; cmd_store = 1'b0; cmd_pre = 1'b0; cmd_wb = 1'b0;
        cmd_dst = 2'd0; cmd_base = 2'd0; cmd_off = 16'h0; mem_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9: every register reads back zero after reset
        for (int r = 0; r < 4; r++) m_reg[r] = 16'h0000;
        for (int r = 0; r < 4; r++) begin
            cmd_valid = 1'b1; cmd_store = 1'b1; cmd_pre = 1'b1; cmd_wb = 1'b0;
            cmd_dst = 2'(r); cmd_base = 2'(r); cmd_off = 16'h0; mem_ready = 1'b1;
            #1;
            chk("R9 reset value", mem_wdata, 16'h0000);
            @(negedge clk);
        end
        cmd_valid = 1'b0; mem_ready = 1'b0;

        // Vector table: mixes modes, updates, collisions, wrap and wait states
        for (int i = 0; i < NV; i++) begin
            op(VEC[i].st, VEC[i].pre, VEC[i].wb, VEC[i].dst, VEC[i].base,
               VEC[i].off, int'(VEC[i].wt), VEC[i].pre ? "R2 pre address" : "R1 post address");
        end
        dump_all("R4 register contents after table");

        // R5: load into its own base with update, post-offset
        op(1'b0, 1'b0, 1'b1, 2'd1, 2'd1, 16'h0040, 0, "R1 post address");
        dump(2'd1, "R5 load data wins collision");

        // R3: pre-offset base update visible next command
        base_before = m_reg[2];
        op(1'b0, 1'b1, 1'b1, 2'd0, 2'd2, 16'h0003, 1, "R2 pre address");
        dump(2'd2, "R3 base updated");
        chk("R3 base is old plus offset", m_reg[2], base_before + 16'h0003);

        // R10: base 0xFFF8 plus 0x0010 wraps to 0x0008
        op(1'b0, 1'b1, 1'b0, 2'd3, 2'd0, 16'(16'd200 - m_reg[0]), 0, "R2 pre address");
        chk("R10 base loaded near top", m_reg[3], 16'hFFF8);
        op(1'b0, 1'b0, 1'b1, 2'd1, 2'd3, 16'h0010, 0, "R1 post address");
        dump(2'd3, "R10 wrapped base");
        chk("R10 model wrap", m_reg[3], 16'h0008);

        // R7: no base update when disabled
        op(1'b1, 1'b0, 1'b0, 2'd0, 2'd2, 16'h0055, 0, "R1 post address");
        dump(2'd2, "R7 base unchanged");

        // R8/R11: idle with ready high and no command
        mem_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk("R11 no request when idle", {15'd0, mem_valid}, 16'd0);
            @(negedge clk);
        end
        mem_ready = 1'b0;
        dump_all("R8 registers held while idle");

        finish_run();
    end
endmodule